// File: doc/BRIEF.md
# Windowed Spike-Timing Weight Updater

This block stores the synaptic weights of one postsynaptic neuron column and applies a simplified spike-timing learning rule to them. It tracks, for each presynaptic input, how many millisecond ticks have passed since that input last spiked. When the postsynaptic neuron fires, the block walks over every synapse in the column. A synapse whose input spiked recently enough is strengthened. Every other synapse is weakened by a small amount. The step size follows a saturating exponential law, so it shrinks as the weight approaches the bound it is moving toward.

Weights are 16-bit unsigned fractions, where 65535 stands for 1.0. The exponential factor is taken from a table that is computed at elaboration, with one table for each selectable steepness. A host port can write and read weights while the block is idle. Learning can be turned off so that labelling and test runs leave the weights untouched. The controller has two states. ST_IDLE moves to ST_SWEEP when a postsynaptic spike arrives while learning is enabled. ST_SWEEP goes back to ST_IDLE after the last synapse has been written, or at once if learning is disabled.

Top module: `stdp_weight_sweeper`

## Requirements
- R1: After reset every weight reads 7 (the lower bound), `busy` is low, and every input counts as stale, having had no recent spike.
- R2: A presynaptic spike sets that input's age to 0, and each `ms_tick` adds 1. The age stops counting once it is past the window. At a postsynaptic event an input is "recent" exactly when its age is at most `window_ms`, so 25 ticks is inside a window of 25 and 26 ticks is outside it.
- R3: `window_ms` is a runtime input. Any value from 15 to 65 ms behaves as R2 describes.
- R4: Potentiation: index k = (w − 7) >> 10, taking k = 0 when w ≤ 7. The factor is f = round(65535·exp(−β·k/64)), the step is (655·f) >> 16, and the new weight is w + step.
- R5: Depression: index k = (65535 − w) >> 10. The factor f is computed as in R4, the step is (328·f) >> 16, and the new weight is w − step.
- R6: `beta_sel` selects β: 0 gives 1.5, 1 gives 1.8, 2 gives 2.0 and 3 gives 2.5.
- R7: Every result is clamped to the range 7 to 65535. Potentiation at 65535 stays at 65535, and depression at 7 stays at 7.
- R8: Suppose a postsynaptic spike is sampled at a clock edge while the block is idle and learning is enabled. Then `busy` is high for exactly N_IN cycles after that edge. One synapse is written per clock, in ascending index order, and each input's recent/stale status is frozen at the triggering edge.
- R9: While `learn_en` is low, a postsynaptic spike starts no sweep and changes no weight. If `learn_en` drops during a sweep, the sweep stops and the remaining synapses keep their values.
- R10: A postsynaptic spike that arrives while `busy` is high is ignored. Each synapse is updated only once.
- R11: A host write made while the block is idle stores the written value. `host_rdata` shows the weight at `host_addr` combinationally. A host write made while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ms_tick | input | 1 | One-cycle strobe marking each elapsed millisecond |
| pre_spike | input | N_IN | Presynaptic spike strobes, one per input |
| post_spike | input | 1 | Postsynaptic spike strobe |
| learn_en | input | 1 | Enables weight updates |
| window_ms | input | TS_W | Width of the potentiation window in ms |
| beta_sel | input | 2 | Selects the exponential steepness |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | log2(N_IN) | Host weight index |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Weight at host_addr |
| busy | output | 1 | High while a sweep is in progress |

## Verification
Each sweep starts at the clock edge that samples `post_spike`. The bench drives stimulus on falling edges and counts the falling edges during which `busy` is high, and it expects exactly N_IN of them. Weights are read back only after `busy` has dropped, and the read is taken on a falling edge because `host_rdata` is combinational. For the abort case, `learn_en` is dropped after two writes have completed. The bench then expects `busy` to be low one cycle later and the last synapse to be unchanged. Window boundaries are checked by counting ticks between a presynaptic spike and the postsynaptic one.

// File: rtl/stdp_pkg.sv
package stdp_pkg;

    localparam int WB        = 16;
    localparam int LUT_BITS  = 6;
    localparam int LUT_DEPTH = 1 << LUT_BITS;
    localparam int N_BETA    = 4;
    localparam logic [WB-1:0] G_LO = 16'd7;
    localparam logic [WB-1:0] G_HI = 16'hFFFF;
    localparam int ALPHA_UP   = 655;
    localparam int ALPHA_DOWN = 328;

    typedef enum logic [1:0] {
        BETA_1P5 = 2'd0,
        BETA_1P8 = 2'd1,
        BETA_2P0 = 2'd2,
        BETA_2P5 = 2'd3
    } beta_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SWEEP = 1'b1
    } sweep_state_e;

    function automatic real beta_value(input int b);
        case (b)
            0:       return 1.5;
            1:       return 1.8;
            2:       return 2.0;
            default: return 2.5;
        endcase
    endfunction

    // exp(-beta*k/64) scaled to 65535, evaluated by series expansion
    function automatic int exp_entry(input int b, input int k);
        real x;
        real term;
        real acc;
        x    = beta_value(b) * real'(k) / real'(LUT_DEPTH);
        term = 1.0;
        acc  = 1.0;
        for (int n = 1; n < 40; n++) begin
            term = term * (-x) / real'(n);
            acc  = acc + term;
        end
        return int'(acc * 65535.0);
    endfunction

endpackage

// File: rtl/stdp_age_tracker.sv
module stdp_age_tracker #(
    parameter int N_IN = 16,
    parameter int TS_W = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ms_tick,
    input  logic [N_IN-1:0] pre_spike,
    input  logic [TS_W-1:0] window_ms,
    output logic [N_IN-1:0] recent
);
    localparam logic [TS_W-1:0] AGE_STALE = '1;

    logic [TS_W-1:0] age_q [N_IN];

    for (genvar gi = 0; gi < N_IN; gi++) begin : g_in
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                age_q[gi] <= AGE_STALE;
            end else if (pre_spike[gi]) begin
                age_q[gi] <= '0;
            end else if (ms_tick && (age_q[gi] <= window_ms)) begin
                age_q[gi] <= age_q[gi] + 1'b1;
            end
        end

        assign recent[gi] = (age_q[gi] <= window_ms);

        p_age_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
            pre_spike[gi] |=> (age_q[gi] == '0));

        p_age_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (!pre_spike[gi] && !ms_tick) |=> $stable(age_q[gi]));
    end

endmodule

// File: rtl/stdp_exp_rom.sv
module stdp_exp_rom
    import stdp_pkg::*;
(
    input  logic [1:0]          beta_sel,
    input  logic [LUT_BITS-1:0] idx_up,
    input  logic [LUT_BITS-1:0] idx_down,
    output logic [WB-1:0]       fac_up,
    output logic [WB-1:0]       fac_down
);
    logic [WB-1:0] tab [N_BETA][LUT_DEPTH];

    for (genvar gb = 0; gb < N_BETA; gb++) begin : g_beta
        for (genvar gk = 0; gk < LUT_DEPTH; gk++) begin : g_ent
            localparam logic [WB-1:0] ENTRY = WB'(exp_entry(gb, gk));
            assign tab[gb][gk] = ENTRY;
        end
    end

    assign fac_up   = tab[beta_sel][idx_up];
    assign fac_down = tab[beta_sel][idx_down];

endmodule

// File: rtl/stdp_step_unit.sv
module stdp_step_unit
    import stdp_pkg::*;
(
    input  logic [WB-1:0]       w_in,
    input  logic                potentiate,
    input  logic [WB-1:0]       fac_up,
    input  logic [WB-1:0]       fac_down,
    output logic [LUT_BITS-1:0] idx_up,
    output logic [LUT_BITS-1:0] idx_down,
    output logic [WB-1:0]       w_out
);
    logic [WB-1:0]   dist_lo;
    logic [WB-1:0]   dist_hi;
    logic [2*WB-1:0] prod_up;
    logic [2*WB-1:0] prod_down;
    logic [WB-1:0]   step_up;
    logic [WB-1:0]   step_down;
    logic [WB:0]     sum_up;
    logic [WB:0]     floor_down;

    always_comb begin
        dist_lo  = (w_in > G_LO) ? (w_in - G_LO) : '0;
        dist_hi  = G_HI - w_in;
        idx_up   = dist_lo[WB-1 -: LUT_BITS];
        idx_down = dist_hi[WB-1 -: LUT_BITS];

        prod_up   = (2*WB)'(ALPHA_UP) * {{WB{1'b0}}, fac_up};
        prod_down = (2*WB)'(ALPHA_DOWN) * {{WB{1'b0}}, fac_down};
        step_up   = prod_up[2*WB-1:WB];
        step_down = prod_down[2*WB-1:WB];

        sum_up     = {1'b0, w_in} + {1'b0, step_up};
        floor_down = {1'b0, step_down} + {1'b0, G_LO};

        if (potentiate) begin
            if (sum_up > {1'b0, G_HI}) begin
                w_out = G_HI;
            end else if (sum_up < {1'b0, G_LO}) begin
                w_out = G_LO;
            end else begin
                w_out = sum_up[WB-1:0];
            end
        end else begin
            if ({1'b0, w_in} < floor_down) begin
                w_out = G_LO;
            end else begin
                w_out = w_in - step_down;
            end
        end
    end

endmodule

// File: rtl/stdp_weight_sweeper.sv
module stdp_weight_sweeper
    import stdp_pkg::*;
#(
    parameter int N_IN  = 16,
    parameter int TS_W  = 7,
    localparam int IDX_W = $clog2(N_IN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ms_tick,
    input  logic [N_IN-1:0]  pre_spike,
    input  logic             post_spike,
    input  logic             learn_en,
    input  logic [TS_W-1:0]  window_ms,
    input  logic [1:0]       beta_sel,
    input  logic             host_wr,
    input  logic [IDX_W-1:0] host_addr,
    input  logic [15:0]      host_wdata,
    output logic [15:0]      host_rdata,
    output logic             busy
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_IN - 1);

    sweep_state_e        state_q;
    sweep_state_e        state_d;
    logic [IDX_W-1:0]    idx_q;
    logic [N_IN-1:0]     recent;
    logic [N_IN-1:0]     recent_q;
    logic [WB-1:0]       wmem [N_IN];
    logic                start_sweep;
    logic                sweep_write;
    logic                host_write;
    logic [LUT_BITS-1:0] idx_up;
    logic [LUT_BITS-1:0] idx_down;
    logic [WB-1:0]       fac_up;
    logic [WB-1:0]       fac_down;
    logic [WB-1:0]       w_cur;
    logic [WB-1:0]       w_new;

    stdp_age_tracker #(.N_IN(N_IN), .TS_W(TS_W)) u_age (
        .clk       (clk),
        .rst_n     (rst_n),
        .ms_tick   (ms_tick),
        .pre_spike (pre_spike),
        .window_ms (window_ms),
        .recent    (recent)
    );

    stdp_exp_rom u_rom (
        .beta_sel (beta_sel),
        .idx_up   (idx_up),
        .idx_down (idx_down),
        .fac_up   (fac_up),
        .fac_down (fac_down)
    );

    assign w_cur = wmem[idx_q];

    stdp_step_unit u_step (
        .w_in       (w_cur),
        .potentiate (recent_q[idx_q]),
        .fac_up     (fac_up),
        .fac_down   (fac_down),
        .idx_up     (idx_up),
        .idx_down   (idx_down),
        .w_out      (w_new)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (post_spike && learn_en) state_d = ST_SWEEP;
            end
            ST_SWEEP: begin
                if (!learn_en || (idx_q == LAST_IDX)) state_d = ST_IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs and strobes
    always_comb begin
        busy        = 1'b0;
        start_sweep = 1'b0;
        sweep_write = 1'b0;
        host_write  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                start_sweep = post_spike && learn_en;
                host_write  = host_wr;
            end
            ST_SWEEP: begin
                busy        = 1'b1;
                sweep_write = learn_en;
            end
        endcase
    end

    assign host_rdata = wmem[host_addr];

    // sweep index, frozen recency and weight storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q    <= '0;
            recent_q <= '0;
            for (int i = 0; i < N_IN; i++) wmem[i] <= G_LO;
        end else begin
            if (start_sweep) begin
                idx_q    <= '0;
                recent_q <= recent;
            end else if (sweep_write) begin
                idx_q <= idx_q + 1'b1;
            end
            if (sweep_write) begin
                wmem[idx_q] <= w_new;
            end else if (host_write) begin
                wmem[host_addr] <= host_wdata;
            end
        end
    end

    p_sweep_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && post_spike && learn_en) |=> (busy && idx_q == '0));

    p_sweep_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && learn_en && idx_q == LAST_IDX) |=> !busy);

    p_sweep_runs_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && learn_en && idx_q != LAST_IDX) |=> (busy && idx_q == $past(idx_q) + 1'b1));

    p_disable_stops_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !learn_en |=> !busy);

    p_direction_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (recent_q[idx_q] ? (w_new >= w_cur || w_new == G_LO) : (w_new <= w_cur || w_new == G_LO)));

    p_bounds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (w_new >= G_LO));

endmodule

// File: tb/stdp_weight_sweeper_tb_top.sv
module stdp_weight_sweeper_tb_top;
    localparam int N_IN = 16;
    localparam int TS_W = 7;
    localparam int IDX_W = $clog2(N_IN);
    localparam int G_LO = 7;
    localparam int G_HI = 65535;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ms_tick = 1'b0;
    logic [N_IN-1:0]  pre_spike = '0;
    logic             post_spike = 1'b0;
    logic             learn_en = 1'b1;
    logic [TS_W-1:0]  window_ms = 7'd25;
    logic [1:0]       beta_sel = 2'd0;
    logic             host_wr = 1'b0;
    logic [IDX_W-1:0] host_addr = '0;
    logic [15:0]      host_wdata = '0;
    logic [15:0]      host_rdata;
    logic             busy;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    stdp_weight_sweeper #(.N_IN(N_IN), .TS_W(TS_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .pre_spike(pre_spike),
        .post_spike(post_spike), .learn_en(learn_en), .window_ms(window_ms),
        .beta_sel(beta_sel), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .busy(busy)
    );

    // vector: beta(2) | start weight(16) | ticks after pre spike(8) | window(7)
    localparam int NV = 8;
    localparam logic [32:0] VEC [NV] = '{
        {2'd0, 16'h8000, 8'd5,  7'd25},
        {2'd1, 16'h1000, 8'd25, 7'd25},
        {2'd2, 16'hC000, 8'd26, 7'd25},
        {2'd3, 16'h0200, 8'd0,  7'd25},
        {2'd0, 16'hF000, 8'd15, 7'd15},
        {2'd3, 16'h4000, 8'd16, 7'd15},
        {2'd2, 16'h6000, 8'd65, 7'd65},
        {2'd1, 16'hFFF0, 8'd10, 7'd65}
    };

    function automatic int expect_w(input int w, input bit pot, input int b);
        real beta;
        int k;
        int f;
        int step;
        int r;
        case (b)
            0: beta = 1.5;
            1: beta = 1.8;
            2: beta = 2.0;
            default: beta = 2.5;
        endcase
        if (pot) k = (w > G_LO) ? ((w - G_LO) >> 10) : 0;
        else     k = (G_HI - w) >> 10;
        f = int'($exp(-beta * real'(k) / 64.0) * 65535.0);
        if (pot) begin
            step = (655 * f) >> 16;
            r = w + step;
        end else begin
            step = (328 * f) >> 16;
            r = w - step;
        end
        if (r > G_HI) r = G_HI;
        if (r < G_LO) r = G_LO;
        return r;
    endfunction

    task automatic check(input string req, input int act, input int exp_v);
        checks++;
        if (act != exp_v) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    task automatic host_write(input int a, input int v);
        @(negedge clk);
        host_wr = 1'b1; host_addr = IDX_W'(a); host_wdata = 16'(v);
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic read_w(input int a, output int v);
        @(negedge clk);
        host_addr = IDX_W'(a);
        #1 v = int'(host_rdata);
    endtask

    task automatic pulse_pre(input int i);
        @(negedge clk);
        pre_spike[i] = 1'b1;
        @(negedge clk);
        pre_spike = '0;
    endtask

    task automatic tick();
        @(negedge clk);
        ms_tick = 1'b1;
        @(negedge clk);
        ms_tick = 1'b0;
    endtask

    // pulse post and return busy-cycle count
    task automatic post_and_wait(output int cnt);
        @(negedge clk);
        post_spike = 1'b1;
        @(negedge clk);
        post_spike = 1'b0;
        cnt = 0;
        while (busy && cnt < 1000) begin
            cnt++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int v;
        int cnt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 busy", int'(busy), 0);
        read_w(0, v);  check("R1 w0", v, G_LO);
        read_w(15, v); check("R1 w15", v, G_LO);

        // vector walk: R2 R3 R4 R5 R6 R8
        for (int n = 0; n < NV; n++) begin
            int b;
            int w0;
            int tk;
            int win;
            b   = int'(VEC[n][32:31]);
            w0  = int'(VEC[n][30:15]);
            tk  = int'(VEC[n][14:7]);
            win = int'(VEC[n][6:0]);
            beta_sel  = 2'(b);
            window_ms = 7'(win);
            host_write(3, w0);
            host_write(5, w0);
            pulse_pre(3);
            for (int t = 0; t < tk; t++) tick();
            post_and_wait(cnt);
            check("R8 busy cycles", cnt, N_IN);
            read_w(3, v);
            check("R2 R3 R4 R6 spiked input", v, expect_w(w0, (tk <= win), b));
            read_w(5, v);
            check("R5 R6 silent input", v, expect_w(w0, 1'b0, b));
        end

        // R7 lower clamp: input 0 stays at the floor after repeated depression
        read_w(0, v); check("R7 floor", v, G_LO);

        // R7 upper clamp
        beta_sel = 2'd0; window_ms = 7'd25;
        host_write(2, G_HI);
        pulse_pre(2);
        post_and_wait(cnt);
        read_w(2, v); check("R7 ceiling", v, G_HI);

        // R9 learning disabled: no sweep, no change
        host_write(9, 16'h5000);
        learn_en = 1'b0;
        @(negedge clk); post_spike = 1'b1;
        @(negedge clk); post_spike = 1'b0;
        check("R9 no busy", int'(busy), 0);
        read_w(9, v); check("R9 weight held", v, 16'h5000);
        learn_en = 1'b1;

        // R10 and R11: post and host write during sweep are ignored
        host_write(7, 16'h3000);
        @(negedge clk); post_spike = 1'b1;
        @(negedge clk); post_spike = 1'b0;
        host_wr = 1'b1; host_addr = 4'd7; host_wdata = 16'h1111;
        @(negedge clk); host_wr = 1'b0; post_spike = 1'b1;
        @(negedge clk); post_spike = 1'b0;
        cnt = 0;
        while (busy && cnt < 1000) begin cnt++; @(negedge clk); end
        @(negedge clk);
        check("R10 no retrigger", int'(busy), 0);
        read_w(7, v); check("R10 R11 single depression", v, expect_w(16'h3000, 1'b0, 0));

        // R11 idle write visible
        host_write(4, 16'h2345);
        read_w(4, v); check("R11 idle write", v, 16'h2345);

        // R9 abort mid sweep
        host_write(15, 16'h7000);
        @(negedge clk); post_spike = 1'b1;
        @(negedge clk); post_spike = 1'b0;
        @(negedge clk);
        @(negedge clk);
        learn_en = 1'b0;
        @(negedge clk);
        check("R9 abort busy", int'(busy), 0);
        read_w(15, v); check("R9 abort untouched", v, 16'h7000);
        learn_en = 1'b1;

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule